// File: doc/BRIEF.md
# Outbound Message Queue Prefetch Reader

This block answers host reads of an outbound message-queue register. The queue itself is a circular post list of message frame addresses held in secondary memory. The block tracks the list with a head index and a count of posted entries. It keeps a two-word prefetch buffer so that most host reads complete at once.

When the buffer is empty and entries remain, a host read is told to retry. At the same time the block fetches one or two words starting at the head address, over a simple request/response memory master port. The host repeats the read and receives the fetched word. When nothing is pending, the read completes at once with all-ones.

A level interrupt tells the host that entries are waiting. The software that produces entries bumps the count with a post strobe, or loads it directly.

Top module: `omq_prefetch_reader`

## Requirements
- R1: When the prefetch buffer holds one or more words, a host read completes in the same cycle (ack high, retry low). It returns the buffered words in the order of their memory addresses.
- R2: When the buffer is empty and the count is non-zero, a host read gets retry and no ack. A memory read is then requested at the head address.
- R3: A refill reads two words when the count is 2 or more and the head index is not the last slot of the region. Otherwise it reads one word. mem_two_o = 1 means two words.
- R4: When the last data beat of a refill arrives, the count drops by the refill length and the head index advances by that length, modulo the region size.
- R5: When the buffer is empty, no refill is pending and the count is zero, a host read is acked at once with data 32'hFFFF_FFFF. It requests no memory read and leaves the count unchanged.
- R6: irq_o is high exactly when irq_mask_i is low and either the count is non-zero or the buffer holds a word.
- R7: A host read that takes the last buffered word while the count is non-zero starts a refill by itself. No further host read is needed to start it.
- R8: sz_sel_i = s selects a region of 256 << s entries (s = 0..7). The memory word address is base_addr_i with its low 8+s bits replaced by the head index. The index wraps from the top of the region to 0.
- R9: At most one refill is outstanding. A host read while a refill is pending gets retry and requests no new read.
- R10: post_i adds 1 to the count in the same cycle that a refill subtracts its length, and both changes take effect. cnt_load_i sets the count to cnt_load_val_i.
- R11: mem_req_o, mem_addr_o and mem_two_o stay stable until mem_ready_i accepts the request. Data beats then arrive on mem_rvalid_i, lower address first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sz_sel_i | input | 3 | Region size select, 256 << value entries |
| base_addr_i | input | 30 | Region base word address; the low index bits are ignored |
| host_rd_i | input | 1 | Host read of the queue register |
| host_ack_o | output | 1 | Read completes this cycle |
| host_retry_o | output | 1 | Read must be repeated later |
| host_rdata_o | output | 32 | Read data, valid with ack |
| mem_req_o | output | 1 | Memory read request |
| mem_ready_i | input | 1 | Request accepted |
| mem_addr_o | output | 30 | Start word address of the read |
| mem_two_o | output | 1 | 1: two-word read, 0: one word |
| mem_rvalid_i | input | 1 | Data beat valid |
| mem_rdata_i | input | 32 | Data beat |
| post_i | input | 1 | Add one posted entry |
| cnt_load_i | input | 1 | Load the posted count |
| cnt_load_val_i | input | 16 | Value to load |
| irq_mask_i | input | 1 | Forces the interrupt low |
| irq_o | output | 1 | Entries pending |

## Verification
The bench first drains a short list of five entries. This separates a buffered hit from an empty-buffer retry, and a two-word refill from the one-word refill chosen when a single entry remains. It also shows a refill started by the draining read alone. Back-to-back reads during a pending refill, and post strobes held across the moment the refill completes, show whether an extra request is issued and whether a simultaneous increment is lost. Full drains of more entries than the region holds, at two size settings, sweep every head index through the wrap. Each request's address and length is compared with values computed arithmetically from the count and the index. Each returned word is compared with its expected address.

// File: rtl/omq_pkg.sv
package omq_pkg;
  localparam int SZ_SEL_W   = 3;
  localparam int BASE_IDX_W = 8;
  localparam int MAX_IDX_W  = BASE_IDX_W + (1 << SZ_SEL_W) - 1;
  localparam int CNT_W      = MAX_IDX_W + 1;

  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_DATA} fetch_st_e;

  function automatic logic [MAX_IDX_W-1:0] idx_mask(input logic [SZ_SEL_W-1:0] sel);
    return MAX_IDX_W'((32'd1 << (BASE_IDX_W + 32'(sel))) - 32'd1);
  endfunction
endpackage

// File: rtl/omq_head_ctr.sv
module omq_head_ctr
  import omq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SZ_SEL_W-1:0]  sz_sel_i,
  input  logic                 post_i,
  input  logic                 load_i,
  input  logic [CNT_W-1:0]     load_val_i,
  input  logic                 take_i,
  input  logic                 take_two_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [MAX_IDX_W-1:0] idx_o
);
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [MAX_IDX_W-1:0] idx_q, idx_d;
  logic [1:0]           take_len;

  assign take_len = take_i ? (take_two_i ? 2'd2 : 2'd1) : 2'd0;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(post_i) - CNT_W'(take_len);
    if (load_i) cnt_d = load_val_i;
    idx_d = (idx_q + MAX_IDX_W'(take_len)) & idx_mask(sz_sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign cnt_o = cnt_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/omq_fetch_eng.sv
module omq_fetch_eng
  import omq_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_two_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              busy_o,
  output logic              mem_req_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_two_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              beat_we_o,
  output logic              beat_sel_o,
  output logic [DATA_W-1:0] beat_data_o,
  output logic              done_o,
  output logic              done_two_o
);
  fetch_st_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              two_q;
  logic              beat_q;
  logic              last_beat;

  assign last_beat = mem_rvalid_i && (beat_q == two_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE: if (start_i)     st_d = FS_REQ;
      FS_REQ:  if (mem_ready_i) st_d = FS_DATA;
      FS_DATA: if (last_beat)   st_d = FS_IDLE;
      default:                  st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      two_q  <= 1'b0;
      beat_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == FS_IDLE && start_i) begin
        addr_q <= start_addr_i;
        two_q  <= start_two_i;
      end
      if (st_q == FS_REQ) beat_q <= 1'b0;
      else if (st_q == FS_DATA && mem_rvalid_i) beat_q <= 1'b1;
    end
  end

  assign busy_o      = st_q != FS_IDLE;
  assign mem_req_o   = st_q == FS_REQ;
  assign mem_addr_o  = addr_q;
  assign mem_two_o   = two_q;
  assign beat_we_o   = st_q == FS_DATA && mem_rvalid_i;
  assign beat_sel_o  = beat_q;
  assign beat_data_o = mem_rdata_i;
  assign done_o      = st_q == FS_DATA && last_beat;
  assign done_two_o  = two_q;
endmodule

// File: rtl/omq_prefetch_buf.sv
module omq_prefetch_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              commit_two_i,
  input  logic              pop_i,
  output logic [1:0]        cnt_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [1:0]        cnt_q;
  logic              rd_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        slot_q[i] <= '0;
      else if (wr_i && wr_sel_i == 1'(i)) slot_q[i] <= wr_data_i;
    end
  end

  // commit only happens while empty, so it never meets a pop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rd_q  <= 1'b0;
    end else if (commit_i) begin
      cnt_q <= commit_two_i ? 2'd2 : 2'd1;
      rd_q  <= 1'b0;
    end else if (pop_i && cnt_q != 2'd0) begin
      cnt_q <= cnt_q - 2'd1;
      rd_q  <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign rdata_o = slot_q[rd_q];
endmodule

// File: rtl/omq_prefetch_reader.sv
module omq_prefetch_reader
  import omq_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SZ_SEL_W-1:0] sz_sel_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic                host_rd_i,
  output logic                host_ack_o,
  output logic                host_retry_o,
  output logic [DATA_W-1:0]   host_rdata_o,
  output logic                mem_req_o,
  input  logic                mem_ready_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_two_o,
  input  logic                mem_rvalid_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                post_i,
  input  logic                cnt_load_i,
  input  logic [CNT_W-1:0]    cnt_load_val_i,
  input  logic                irq_mask_i,
  output logic                irq_o
);
  logic [CNT_W-1:0]     post_cnt;
  logic [MAX_IDX_W-1:0] head_idx, idx_msk;
  logic [ADDR_W-1:0]    msk_a, head_addr;
  logic [1:0]           buf_cnt;
  logic [DATA_W-1:0]    buf_rdata;
  logic                 fetch_busy, fetch_done, fetch_done_two;
  logic                 beat_we, beat_sel;
  logic [DATA_W-1:0]    beat_data;
  logic                 buf_has, rd_hit, rd_none, start, start_two;

  assign idx_msk   = idx_mask(sz_sel_i);
  assign msk_a     = ADDR_W'(idx_msk);
  assign head_addr = (base_addr_i & ~msk_a) | (ADDR_W'(head_idx) & msk_a);

  assign buf_has   = buf_cnt != 2'd0;
  assign rd_hit    = host_rd_i && buf_has;
  assign rd_none   = host_rd_i && !buf_has && !fetch_busy && post_cnt == '0;
  // refill on an empty read or on the read that drains the last word
  assign start     = host_rd_i && !fetch_busy && post_cnt != '0 && buf_cnt <= 2'd1;
  // a two-word burst never crosses the top of the region
  assign start_two = post_cnt >= CNT_W'(2) && head_idx != idx_msk;

  assign host_ack_o   = rd_hit || rd_none;
  assign host_retry_o = host_rd_i && !host_ack_o;
  assign host_rdata_o = buf_has ? buf_rdata : '1;
  assign irq_o        = !irq_mask_i && (post_cnt != '0 || buf_has);

  omq_head_ctr u_head (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sz_sel_i   (sz_sel_i),
    .post_i     (post_i),
    .load_i     (cnt_load_i),
    .load_val_i (cnt_load_val_i),
    .take_i     (fetch_done),
    .take_two_i (fetch_done_two),
    .cnt_o      (post_cnt),
    .idx_o      (head_idx)
  );

  omq_fetch_eng #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_two_i  (start_two),
    .start_addr_i (head_addr),
    .busy_o       (fetch_busy),
    .mem_req_o    (mem_req_o),
    .mem_ready_i  (mem_ready_i),
    .mem_addr_o   (mem_addr_o),
    .mem_two_o    (mem_two_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .beat_we_o    (beat_we),
    .beat_sel_o   (beat_sel),
    .beat_data_o  (beat_data),
    .done_o       (fetch_done),
    .done_two_o   (fetch_done_two)
  );

  omq_prefetch_buf #(.DATA_W(DATA_W), .DEPTH(2)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (beat_we),
    .wr_sel_i     (beat_sel),
    .wr_data_i    (beat_data),
    .commit_i     (fetch_done),
    .commit_two_i (fetch_done_two),
    .pop_i        (rd_hit),
    .cnt_o        (buf_cnt),
    .rdata_o      (buf_rdata)
  );
endmodule

// File: rtl/omq_prefetch_reader_chk.sv
module omq_prefetch_reader_chk
  import omq_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_rd_i,
  input logic              host_ack_o,
  input logic              host_retry_o,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_two_o,
  input logic              post_i,
  input logic              cnt_load_i,
  input logic              irq_mask_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [1:0]        buf_cnt_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              done_two_i
);
  assert_hit_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && buf_cnt_i != 2'd0 |-> host_ack_o && !host_retry_o);

  assert_miss_retry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && buf_cnt_i == 2'd0 && cnt_i != '0 |-> host_retry_o && !host_ack_o);

  assert_two_needs_two_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_two_o |-> cnt_i >= CNT_W'(2));

  assert_cnt_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !post_i && !cnt_load_i |=>
      cnt_i == $past(cnt_i) - ($past(done_two_i) ? CNT_W'(2) : CNT_W'(1)));

  assert_empty_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && buf_cnt_i == 2'd0 && cnt_i == '0 && !busy_i |->
      host_ack_o && host_rdata_o == '1);

  assert_irq_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_i |-> !irq_o);

  assert_irq_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_mask_i && (cnt_i != '0 || buf_cnt_i != 2'd0) |-> irq_o);

  assert_busy_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> buf_cnt_i == 2'd0);

  assert_busy_retry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && host_rd_i |-> host_retry_o);

  assert_post_inc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_i && !cnt_load_i && !done_i |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_two_o));
endmodule

bind omq_prefetch_reader omq_prefetch_reader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_rd_i    (host_rd_i),
  .host_ack_o   (host_ack_o),
  .host_retry_o (host_retry_o),
  .host_rdata_o (host_rdata_o),
  .mem_req_o    (mem_req_o),
  .mem_ready_i  (mem_ready_i),
  .mem_addr_o   (mem_addr_o),
  .mem_two_o    (mem_two_o),
  .post_i       (post_i),
  .cnt_load_i   (cnt_load_i),
  .irq_mask_i   (irq_mask_i),
  .irq_o        (irq_o),
  .cnt_i        (post_cnt),
  .buf_cnt_i    (buf_cnt),
  .busy_i       (fetch_busy),
  .done_i       (fetch_done),
  .done_two_i   (fetch_done_two)
);

// File: tb/omq_prefetch_reader_tb.sv
module omq_prefetch_reader_tb_top;
  import omq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam logic [AW-1:0] BASE = 30'h1234_5ABC;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [SZ_SEL_W-1:0] sz_sel = '0;
  logic host_rd = 1'b0, host_ack, host_retry;
  logic [DW-1:0] host_rdata;
  logic mem_req, mem_ready = 1'b0, mem_two, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic post = 1'b0, cnt_load = 1'b0, irq_mask = 1'b0, irq;
  logic [CNT_W-1:0] cnt_load_val = '0;

  int n_chk = 0, n_bad = 0;
  int req_cnt = 0;
  int exp_cnt = 0, exp_idx = 0, exp_rd_idx = 0;
  int beats = 0;
  bit waitf = 0;
  logic [AW-1:0] baddr = '0, wait_addr = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  omq_prefetch_reader dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sz_sel_i(sz_sel), .base_addr_i(BASE),
    .host_rd_i(host_rd), .host_ack_o(host_ack), .host_retry_o(host_retry),
    .host_rdata_o(host_rdata), .mem_req_o(mem_req), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_two_o(mem_two), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .post_i(post), .cnt_load_i(cnt_load),
    .cnt_load_val_i(cnt_load_val), .irq_mask_i(irq_mask), .irq_o(irq)
  );

  function automatic int region_sz();
    return 256 << sz_sel;
  endfunction

  function automatic logic [AW-1:0] word_addr(input int idx);
    logic [AW-1:0] m;
    m = AW'(region_sz() - 1);
    return (BASE & ~m) | (AW'(idx) & m);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: one stall cycle per request, then beats on following cycles
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      beats = 0; mem_rvalid = 1'b0; mem_ready = 1'b0; waitf = 0;
    end else begin
      if (beats > 0) begin
        mem_rvalid = 1'b1; mem_rdata = {2'b11, baddr}; baddr = baddr + 1'b1; beats--;
      end else mem_rvalid = 1'b0;
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_req) begin
        if (!waitf) begin
          waitf = 1; wait_addr = mem_addr;
        end else begin
          bit two;
          waitf = 0; mem_ready = 1'b1; req_cnt++;
          chk(mem_addr == wait_addr, "R11 addr held", 32'(mem_addr), 32'(wait_addr));
          two = exp_cnt >= 2 && exp_idx != region_sz() - 1;
          chk(mem_two == two, "R3 refill length", 32'(mem_two), 32'(two));
          chk(mem_addr == word_addr(exp_idx), "R2 R8 refill address", 32'(mem_addr), 32'(word_addr(exp_idx)));
          baddr = mem_addr;
          beats = two ? 2 : 1;
          exp_cnt -= beats;
          exp_idx = (exp_idx + beats) % region_sz();
        end
      end
    end
  end

  task automatic do_read(output logic ack, output logic rty, output logic [31:0] d);
    @(negedge clk_i);
    host_rd = 1'b1;
    #1;
    ack = host_ack; rty = host_retry; d = host_rdata;
    @(posedge clk_i);
    #1 host_rd = 1'b0;
  endtask

  task automatic read_until_ack(output logic [31:0] d, output int tries);
    logic ack, rty;
    tries = 0;
    d = '0;
    for (int k = 0; k < 40; k++) begin
      do_read(ack, rty, d);
      tries++;
      if (ack) break;
      repeat (2) @(posedge clk_i);
    end
  endtask

  task automatic load_cnt(input int v);
    @(negedge clk_i);
    cnt_load = 1'b1; cnt_load_val = CNT_W'(v); exp_cnt = v;
    @(posedge clk_i);
    #1 cnt_load = 1'b0;
  endtask

  task automatic check_word(input logic [31:0] d, input string rq);
    logic [31:0] e;
    e = {2'b11, word_addr(exp_rd_idx)};
    chk(d == e, rq, d, e);
    exp_rd_idx = (exp_rd_idx + 1) % region_sz();
  endtask

  task automatic drain_all(output int n);
    logic [31:0] d;
    int t;
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      read_until_ack(d, t);
      if (d == 32'hFFFF_FFFF) break;
      check_word(d, "R4 R8 word order");
      n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    exp_cnt = 0; exp_idx = 0; exp_rd_idx = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack, rty;
    logic [31:0] d;
    int t, n, rc;

    do_reset();
    #2;
    chk(irq == 1'b0, "R6 reset irq", 32'(irq), 0);
    chk(mem_req == 1'b0, "R11 reset req", 32'(mem_req), 0);

    // R5: empty read
    do_read(ack, rty, d);
    chk(ack && !rty, "R5 empty ack", {30'd0, ack, rty}, 32'h2);
    chk(d == 32'hFFFF_FFFF, "R5 empty data", d, 32'hFFFF_FFFF);
    repeat (4) @(posedge clk_i);
    chk(req_cnt == 0, "R5 no request", 32'(req_cnt), 0);

    // R5: count unchanged -> one post gives a one-word refill (checked by model)
    @(negedge clk_i); post = 1'b1; exp_cnt++;
    @(negedge clk_i); post = 1'b0;
    read_until_ack(d, t);
    chk(t > 1, "R2 retry on miss", 32'(t), 2);
    check_word(d, "R5 single word after post");

    // R6 irq and mask
    load_cnt(5);
    #2 chk(irq == 1'b1, "R6 irq pending", 32'(irq), 1);
    irq_mask = 1'b1; #1;
    chk(irq == 1'b0, "R6 irq masked", 32'(irq), 0);
    irq_mask = 1'b0; #1;

    rc = req_cnt;
    do_read(ack, rty, d);
    chk(rty && !ack, "R2 miss retry", {30'd0, ack, rty}, 32'h1);
    repeat (6) @(posedge clk_i);
    chk(req_cnt == rc + 1, "R2 one request", 32'(req_cnt), 32'(rc + 1));
    do_read(ack, rty, d);
    chk(ack, "R1 hit first", 32'(ack), 1);
    check_word(d, "R1 first word");
    do_read(ack, rty, d);
    chk(ack, "R1 hit second", 32'(ack), 1);
    check_word(d, "R1 second word");
    repeat (6) @(posedge clk_i);
    chk(req_cnt == rc + 2, "R7 auto refill", 32'(req_cnt), 32'(rc + 2));
    do_read(ack, rty, d); chk(ack, "R1 hit third", 32'(ack), 1); check_word(d, "R1 third");
    do_read(ack, rty, d); chk(ack, "R1 hit fourth", 32'(ack), 1); check_word(d, "R1 fourth");
    repeat (6) @(posedge clk_i);
    chk(req_cnt == rc + 3, "R7 auto refill last", 32'(req_cnt), 32'(rc + 3));
    do_read(ack, rty, d); chk(ack, "R1 hit fifth", 32'(ack), 1); check_word(d, "R1 fifth");
    #2 chk(irq == 1'b0, "R6 irq drops", 32'(irq), 0);
    do_read(ack, rty, d);
    chk(ack && d == 32'hFFFF_FFFF, "R5 after drain", d, 32'hFFFF_FFFF);

    // R9: repeated read while refill pending
    load_cnt(2);
    rc = req_cnt;
    do_read(ack, rty, d);
    do_read(ack, rty, d);
    chk(rty && !ack, "R9 retry while pending", {30'd0, ack, rty}, 32'h1);
    repeat (6) @(posedge clk_i);
    chk(req_cnt == rc + 1, "R9 single outstanding", 32'(req_cnt), 32'(rc + 1));
    drain_all(n);
    chk(n == 2, "R9 drained", 32'(n), 2);

    // R10: posts held across refill completion
    load_cnt(4);
    do_read(ack, rty, d);
    @(negedge clk_i); post = 1'b1; exp_cnt += 6;
    repeat (6) @(negedge clk_i);
    post = 1'b0;
    drain_all(n);
    chk(n == 10, "R10 post and take", 32'(n), 10);

    // R8 R3 R4: sweep through the wrap, 256 entries
    load_cnt(300);
    drain_all(n);
    chk(n == 300, "R8 sweep 256", 32'(n), 300);

    // 512-entry region
    do_reset();
    sz_sel = 3'd1;
    load_cnt(600);
    drain_all(n);
    chk(n == 600, "R8 sweep 512", 32'(n), 600);
    #2 chk(irq == 1'b0, "R6 final irq", 32'(irq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule